// File: doc/BRIEF.md
# Runtime-Selectable Serial CRC Engine

This block computes and checks cyclic redundancy codes one bit per clock. A single 32-bit shift register with feedback performs modulo-2 division by one of four generator polynomials. The polynomial is picked on a select input when a frame starts. In send direction the block echoes each message bit on its serial output. After the last message bit it shifts out the remainder of the message multiplied by x^n and divided by the generator, where n is the generator degree. The resulting frame is therefore exactly divisible by the generator.

In check direction the same register divides the whole received frame, check bits included. When the last bit arrives the block raises an accept flag if the remainder is zero. A correct frame always leaves zero because the remainder cancels itself under XOR arithmetic. A start strobe clears the register and latches the direction and polynomial. Message bits enter most significant first, qualified by a valid strobe. An end-of-message strobe is given together with the last bit.

Top module: `crcu_top`

## Requirements
- R1: While reset is held and on the first cycle after it, `sout_valid`, `chk_active` and `accept` are all 0.
- R2: `poly_sel` is sampled only in the cycle `start` is high. The encodings are 0 = x^12+x^11+x^3+x^2+x+1, 1 = x^16+x^15+x^2+1, 2 = x^16+x^12+x^5+1 and 3 = the degree-32 generator with terms 32,26,23,22,16,12,11,10,8,7,5,4,2,1,0. A change of `poly_sel` after `start` has no effect on the frame in progress.
- R3: In send direction (`mode`=0), every bit accepted with `din_valid` appears on `sout` with `sout_valid` high on the cycle after it is taken. Bits are kept in arrival order, which is most significant first.
- R4: In send direction, the cycles after the bit taken with `eom` carry n check bits on `sout` without a gap, most significant first, with `chk_active` high on exactly those n cycles. The check bits equal the remainder of x^n·M(x) divided by the generator, where n is the generator degree.
- R5: Cycles with `din_valid` low inside a frame shift nothing, so the frame and its check bits are the same as without the idle cycles.
- R6: In check direction (`mode`=1), `accept` is updated on the cycle after the bit taken with `eom`. It is 1 exactly when the remainder of the full received frame is zero, and it holds that value until the next `start`.
- R7: A valid frame altered by a single-bit error, a double-bit error, or a burst of length no more than n yields `accept`=0.
- R8: `start` clears the remainder register and `accept`, and it abandons any frame or check-bit output in progress. The next frame's result equals that of a frame begun from idle.
- R9: For generators narrower than 32 bits, the register bits above the degree stay at zero and take no part in the zero-remainder test. Results for narrow generators do not depend on earlier wide-generator frames.
- R10: In check direction `sout_valid` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Begin a frame; clears the register, latches `mode` and `poly_sel` |
| mode | input | 1 | 0 = send (append check bits), 1 = check (test remainder) |
| poly_sel | input | 2 | Generator select, encoded as in R2 |
| din | input | 1 | Serial message or frame bit |
| din_valid | input | 1 | `din` carries a bit this cycle |
| eom | input | 1 | With `din_valid`: this bit is the last of the message or frame |
| sout | output | 1 | Serial output: echoed message bits, then check bits |
| sout_valid | output | 1 | `sout` carries a bit this cycle |
| chk_active | output | 1 | The bit on `sout` is a check bit |
| accept | output | 1 | Check direction: frame remainder was zero |

## Verification
All 256 eight-bit messages are sent under each of the four generators. The serial output is compared with a long-division remainder computed in the bench, so every remainder bit and every tap of each generator is exercised. Some of these frames include idle cycles or change the select input in mid-frame. They show that stalls and late select changes leave the result unchanged. In check direction, correct frames must be accepted. Frames with every single-bit flip, several spacings of double flips, and bursts from length 3 up to the degree must be rejected, which separates real division from a weaker parity-style test. An aborted frame followed by a fresh one, and narrow generators run after the wide one, show that start fully clears state and that the upper register bits play no part.

// File: rtl/crcu_pkg.sv
package crcu_pkg;

    localparam int unsigned CRC_MAX_W = 32;
    localparam int unsigned CNT_W     = $clog2(CRC_MAX_W + 1);

    typedef logic [CRC_MAX_W-1:0] crc_word_t;
    typedef logic [CNT_W-1:0]     crc_cnt_t;

    typedef enum logic [1:0] {
        GEN_C12   = 2'd0,
        GEN_C16   = 2'd1,
        GEN_CCITT = 2'd2,
        GEN_C32   = 2'd3
    } gen_sel_e;

    typedef enum logic {
        DIR_SEND  = 1'b0,
        DIR_CHECK = 1'b1
    } dir_e;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_MSG    = 2'd1,
        ST_APPEND = 2'd2
    } phase_e;

    // Generator description: taps hold every coefficient below the
    // leading term, mask covers the register bits in use.
    typedef struct packed {
        crc_word_t taps;
        crc_word_t mask;
        crc_cnt_t  deg;
    } gen_cfg_t;

    function automatic crc_word_t width_mask(input int unsigned deg);
        crc_word_t m;
        m = '0;
        for (int unsigned i = 0; i < CRC_MAX_W; i++) begin
            if (i < deg) m[i] = 1'b1;
        end
        return m;
    endfunction

    function automatic gen_cfg_t gen_lookup(input gen_sel_e sel);
        gen_cfg_t c;
        case (sel)
            GEN_C12: begin
                c.taps = 32'h0000_080F;
                c.deg  = CNT_W'(12);
            end
            GEN_C16: begin
                c.taps = 32'h0000_8005;
                c.deg  = CNT_W'(16);
            end
            GEN_CCITT: begin
                c.taps = 32'h0000_1021;
                c.deg  = CNT_W'(16);
            end
            default: begin
                c.taps = 32'h04C1_1DB7;
                c.deg  = CNT_W'(32);
            end
        endcase
        c.mask = width_mask(int'(c.deg));
        return c;
    endfunction

endpackage

// File: rtl/crcu_lfsr.sv
module crcu_lfsr
    import crcu_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      clear,
    input  logic      step,
    input  logic      drain,
    input  logic      din,
    input  gen_cfg_t  cfg,
    output crc_word_t rem_q,
    output crc_word_t rem_nxt,
    output logic      msb
);

    crc_word_t top_bit;
    crc_word_t shifted;
    crc_word_t stepped;
    logic      fb;

    // Highest used bit of the register for the selected degree.
    assign top_bit = cfg.mask ^ (cfg.mask >> 1);
    assign msb     = |(rem_q & top_bit);
    assign fb      = din ^ msb;

    // Direct-form division: the incoming bit is folded into the
    // feedback, so no trailing zero bits need to be clocked in.
    generate
        for (genvar i = 0; i < CRC_MAX_W; i++) begin : g_bit
            if (i == 0) begin : g_low
                assign shifted[i] = 1'b0;
            end else begin : g_up
                assign shifted[i] = rem_q[i-1] & cfg.mask[i];
            end
            assign stepped[i] = shifted[i] ^ (fb & cfg.taps[i]);
        end
    endgenerate

    assign rem_nxt = stepped;

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            rem_q <= '0;
        end else if (step) begin
            rem_q <= stepped;
        end else if (drain) begin
            rem_q <= shifted;
        end
    end

    // R9: unused upper register bits never become non-zero.
    a_r9_upper_zero: assert property (@(posedge clk) disable iff (rst)
        (rem_q & ~cfg.mask) == '0);

endmodule

// File: rtl/crcu_ctrl.sv
module crcu_ctrl
    import crcu_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     start,
    input  logic     din_valid,
    input  logic     eom,
    input  dir_e     dir,
    input  crc_cnt_t deg,
    output phase_e   phase_q,
    output logic     take,
    output logic     fin,
    output logic     drain
);

    crc_cnt_t cnt_q;

    always_comb begin
        take  = (phase_q == ST_MSG) && din_valid && !start;
        fin   = take && eom;
        drain = (phase_q == ST_APPEND) && !start;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q <= ST_IDLE;
            cnt_q   <= '0;
        end else if (start) begin
            phase_q <= ST_MSG;
            cnt_q   <= '0;
        end else if (fin) begin
            if (dir == DIR_SEND) begin
                phase_q <= ST_APPEND;
                cnt_q   <= deg - 1'b1;
            end else begin
                phase_q <= ST_IDLE;
            end
        end else if (drain) begin
            if (cnt_q == '0) begin
                phase_q <= ST_IDLE;
            end else begin
                cnt_q <= cnt_q - 1'b1;
            end
        end
    end

    // R4: the check-bit counter stays within the generator degree.
    a_r4_cnt_bound: assert property (@(posedge clk) disable iff (rst)
        (phase_q == ST_APPEND) |-> (cnt_q < deg));

    // R4: the append phase is entered only from a finished send frame.
    a_r4_append_entry: assert property (@(posedge clk) disable iff (rst)
        (fin && dir == DIR_SEND) |=> (phase_q == ST_APPEND));

endmodule

// File: rtl/crcu_top.sv
module crcu_top
    import crcu_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       start,
    input  logic       mode,
    input  logic [1:0] poly_sel,
    input  logic       din,
    input  logic       din_valid,
    input  logic       eom,
    output logic       sout,
    output logic       sout_valid,
    output logic       chk_active,
    output logic       accept
);

    gen_cfg_t  cfg_q;
    dir_e      dir_q;
    phase_e    phase;
    logic      take;
    logic      fin;
    logic      drain;
    crc_word_t rem_q;
    crc_word_t rem_nxt;
    logic      msb;

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q <= gen_lookup(GEN_C12);
            dir_q <= DIR_SEND;
        end else if (start) begin
            cfg_q <= gen_lookup(gen_sel_e'(poly_sel));
            dir_q <= dir_e'(mode);
        end
    end

    crcu_ctrl u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .start     (start),
        .din_valid (din_valid),
        .eom       (eom),
        .dir       (dir_q),
        .deg       (cfg_q.deg),
        .phase_q   (phase),
        .take      (take),
        .fin       (fin),
        .drain     (drain)
    );

    crcu_lfsr u_lfsr (
        .clk     (clk),
        .rst     (rst),
        .clear   (start),
        .step    (take),
        .drain   (drain),
        .din     (din),
        .cfg     (cfg_q),
        .rem_q   (rem_q),
        .rem_nxt (rem_nxt),
        .msb     (msb)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            sout       <= 1'b0;
            sout_valid <= 1'b0;
            chk_active <= 1'b0;
            accept     <= 1'b0;
        end else begin
            sout_valid <= 1'b0;
            chk_active <= 1'b0;
            if (start) begin
                accept <= 1'b0;
            end else if (take) begin
                if (dir_q == DIR_SEND) begin
                    sout       <= din;
                    sout_valid <= 1'b1;
                end else if (fin) begin
                    accept <= (rem_nxt == '0);
                end
            end else if (drain) begin
                sout       <= msb;
                sout_valid <= 1'b1;
                chk_active <= 1'b1;
            end
        end
    end

    // R3: a taken message bit is echoed on the following cycle.
    a_r3_echo: assert property (@(posedge clk) disable iff (rst)
        (take && dir_q == DIR_SEND) |=> (sout_valid && sout == $past(din)));

    // R4: a check bit is always a valid output bit.
    a_r4_chk_valid: assert property (@(posedge clk) disable iff (rst)
        chk_active |-> sout_valid);

    // R6: accept can only be raised by a frame in check direction.
    a_r6_accept_dir: assert property (@(posedge clk) disable iff (rst)
        accept |-> (dir_q == DIR_CHECK));

    // R8: start silences the outputs on the next cycle.
    a_r8_start_clears: assert property (@(posedge clk) disable iff (rst)
        start |=> (!chk_active && !accept && !sout_valid));

    // R10: nothing is emitted in check direction.
    a_r10_rx_quiet: assert property (@(posedge clk) disable iff (rst)
        (dir_q == DIR_CHECK && !start) |=> !sout_valid);

endmodule

// File: tb/sim_crcu_top.sv
module sim_crcu_top;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       start = 1'b0;
    logic       mode = 1'b0;
    logic [1:0] poly_sel = 2'd0;
    logic       din = 1'b0;
    logic       din_valid = 1'b0;
    logic       eom = 1'b0;
    logic       sout;
    logic       sout_valid;
    logic       chk_active;
    logic       accept;

    int n_checks = 0;
    int n_fail   = 0;

    logic [127:0] cap;
    int cap_n     = 0;
    int chk_n     = 0;
    int first_chk = -1;

    always #10 clk = ~clk;   // 50 MHz

    crcu_top u0 (
        .clk        (clk),
        .rst        (rst),
        .start      (start),
        .mode       (mode),
        .poly_sel   (poly_sel),
        .din        (din),
        .din_valid  (din_valid),
        .eom        (eom),
        .sout       (sout),
        .sout_valid (sout_valid),
        .chk_active (chk_active),
        .accept     (accept)
    );

    // Output collector, sampled 5 ns after each rising edge.
    always begin
        @(posedge clk);
        #5;
        if (sout_valid) begin
            cap = {cap[126:0], sout};
            if (chk_active) begin
                if (first_chk < 0) first_chk = cap_n;
                chk_n++;
            end
            cap_n++;
        end
    end

    task automatic check(input bit ok, input string req,
                         input logic [127:0] act, input logic [127:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic int deg_of(input logic [1:0] sel);
        case (sel)
            2'd0:    return 12;
            2'd1:    return 16;
            2'd2:    return 16;
            default: return 32;
        endcase
    endfunction

    function automatic logic [32:0] gen_of(input logic [1:0] sel);
        case (sel)
            2'd0:    return 33'h0_0000_180F;
            2'd1:    return 33'h0_0001_8005;
            2'd2:    return 33'h0_0001_1021;
            default: return 33'h1_04C1_1DB7;
        endcase
    endfunction

    // Long division of a bit string (first bit at index len-1).
    function automatic logic [31:0] ref_rem(input logic [127:0] bits,
                                            input int len, input logic [1:0] sel);
        logic [32:0] r;
        int d;
        d = deg_of(sel);
        r = '0;
        for (int i = len - 1; i >= 0; i--) begin
            r = {r[31:0], bits[i]};
            if (r[d]) r = r ^ gen_of(sel);
        end
        return r[31:0];
    endfunction

    function automatic logic [127:0] make_frame(input logic [127:0] msg,
                                                input int len, input logic [1:0] sel);
        logic [127:0] shifted;
        shifted = msg << deg_of(sel);
        return shifted | 128'(ref_rem(shifted, len + deg_of(sel), sel));
    endfunction

    task automatic drive_frame(input logic m, input logic [1:0] sel,
                               input logic [127:0] bits, input int len,
                               input int gap, input bit swap_sel);
        @(negedge clk);
        start = 1'b1; mode = m; poly_sel = sel;
        cap = '0; cap_n = 0; chk_n = 0; first_chk = -1;
        @(negedge clk);
        start = 1'b0;
        if (swap_sel) poly_sel = sel ^ 2'b01;
        for (int i = len - 1; i >= 0; i--) begin
            din = bits[i]; din_valid = 1'b1; eom = (i == 0);
            @(negedge clk);
            din_valid = 1'b0; eom = 1'b0;
            if (gap > 0) repeat (gap) @(negedge clk);
        end
    endtask

    task automatic send_and_check(input logic [1:0] sel, input logic [127:0] msg,
                                  input int len, input int gap, input bit swap,
                                  input string tag);
        logic [127:0] exp;
        int d;
        d = deg_of(sel);
        exp = make_frame(msg, len, sel);
        drive_frame(1'b0, sel, msg, len, gap, swap);
        repeat (d + 2) @(negedge clk);
        check(cap_n == len + d && cap == exp, tag, cap, exp);
        check(chk_n == d && first_chk == len, {tag, " R4 check-bit flag"},
              128'(chk_n), 128'(d));
    endtask

    task automatic recv_and_check(input logic [1:0] sel, input logic [127:0] frame,
                                  input int len, input logic exp_acc,
                                  input string tag, input bit hold);
        drive_frame(1'b1, sel, frame, len, 0, 1'b0);
        check(accept == exp_acc, tag, 128'(accept), 128'(exp_acc));
        if (hold) begin
            @(negedge clk);
            check(accept == exp_acc, "R6 accept held", 128'(accept), 128'(exp_acc));
            check(cap_n == 0, "R10 no output in check direction", 128'(cap_n), 128'(0));
        end
    endtask

    task automatic finish_up;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog expired actual=running expected=done");
        finish_up();
    end

    initial begin
        logic [127:0] good;
        logic [127:0] emask;
        int d;
        int len;

        repeat (3) @(negedge clk);
        // R1: outputs idle during reset and right after release
        check(!sout_valid && !chk_active && !accept, "R1 during reset",
              {125'd0, sout_valid, chk_active, accept}, 128'd0);
        rst = 1'b0;
        @(negedge clk);
        check(!sout_valid, "R1 sout_valid", 128'(sout_valid), 128'd0);
        check(!chk_active, "R1 chk_active", 128'(chk_active), 128'd0);
        check(!accept, "R1 accept", 128'(accept), 128'd0);

        // R3 R4 exhaustive 8-bit messages for every generator; some with
        // idle gaps (R5) and some with select changed mid-frame (R2)
        for (int s = 0; s < 4; s++) begin
            for (int m = 0; m < 256; m++) begin
                if (m % 5 == 0)
                    send_and_check(2'(s), 128'(m), 8, 2, 1'b0, "R5 gaps R3 R4");
                else if (m % 7 == 3)
                    send_and_check(2'(s), 128'(m), 8, 0, 1'b1, "R2 late select R3 R4");
                else
                    send_and_check(2'(s), 128'(m), 8, 0, 1'b0, "R3 R4 frame");
            end
            send_and_check(2'(s), 128'(40'hA5_3C_96_0F_71), 40, 0, 1'b0, "R4 long message");
        end

        // R6 R7 R9 receive sweep
        for (int s = 3; s >= 0; s--) begin
            d = deg_of(2'(s));
            len = 16 + d;
            for (int m = 0; m < 16; m++) begin
                good = make_frame(128'(16'h005A ^ (m * 16'h1111)), 16, 2'(s));
                recv_and_check(2'(s), good, len, 1'b1, "R6 R9 good frame accepted", m < 2);
            end
            good = make_frame(128'(16'hC3A5), 16, 2'(s));
            good = make_frame(128'(40'hA5_3C_96_0F_71), 40, 2'(s));
            recv_and_check(2'(s), good, 40 + d, 1'b1, "R6 long frame accepted", 1'b1);
            good = make_frame(128'(16'hC3A5), 16, 2'(s));
            for (int p = 0; p < len; p++) begin
                emask = 128'd1 << p;
                recv_and_check(2'(s), good ^ emask, len, 1'b0, "R7 single-bit error", 1'b0);
            end
            for (int k = 0; k < 3; k++) begin
                int sp;
                sp = (k == 0) ? 1 : (k == 1) ? 4 : 9;
                for (int p = 0; p + sp < len; p++) begin
                    emask = (128'd1 << p) | (128'd1 << (p + sp));
                    recv_and_check(2'(s), good ^ emask, len, 1'b0, "R7 double-bit error", 1'b0);
                end
            end
            for (int b = 3; b <= d; b++) begin
                emask = (128'd1 << b) - 128'd1;
                recv_and_check(2'(s), good ^ emask, len, 1'b0, "R7 burst at end", 1'b0);
                recv_and_check(2'(s), good ^ (emask << (len - b)), len, 1'b0,
                               "R7 burst at start", 1'b0);
            end
        end

        // R8: accept cleared by start
        good = make_frame(128'(16'h1234), 16, 2'd2);
        recv_and_check(2'd2, good, 32, 1'b1, "R8 setup accept", 1'b0);
        @(negedge clk);
        start = 1'b1; mode = 1'b0;
        @(negedge clk);
        start = 1'b0;
        check(!accept, "R8 accept cleared by start", 128'(accept), 128'd0);

        // R8: abandoned frame, then a fresh one
        @(negedge clk);
        start = 1'b1; mode = 1'b0; poly_sel = 2'd3;
        @(negedge clk);
        start = 1'b0;
        for (int i = 0; i < 5; i++) begin
            din = i[0]; din_valid = 1'b1;
            @(negedge clk);
        end
        din_valid = 1'b0;
        send_and_check(2'd3, 128'(8'h3C), 8, 0, 1'b0, "R8 after abort");

        // R8: start during check-bit output
        drive_frame(1'b0, 2'd3, 128'(8'hF1), 8, 0, 1'b0);
        repeat (4) @(negedge clk);
        send_and_check(2'd0, 128'(8'h96), 8, 0, 1'b0, "R8 start during append R9");

        finish_up();
    end

endmodule